// File: doc/BRIEF.md
# Dual Wiper and Comparator-Control Register Bank

This block keeps the digital state behind two digitally set resistor dividers and their two voltage comparators. Each of four units holds one live 6-bit register: two wiper position units and two comparator-control units. Each unit also has four stored 6-bit slots that survive a reset. A serial front end decodes host traffic into one-cycle command strobes. This block carries them out: it reads and writes the live registers and the slots, copies between them for one unit or for all units at once, and nudges a wiper one tap at a time.

Writes into the slots behave as nonvolatile writes. Each one starts a write-cycle timer, counted in clocks, during which every command is dropped. When the write-protect input is low, no slot changes and the timer does not start. While reset is held, every live register is reloaded from slot 0 of its unit. Each wiper value is decoded into a one-hot set of 64 tap enables. Each comparator-control value decides whether the external comparator result is passed, frozen or forced low.

Top module: `potbank_ctrl`

## Requirements
- R1: While rst_n is low, each live register is loaded from slot 0 of its unit, with control units masked as in R4. busy and rd_valid read 0 after reset.
- R2: tap_sel[c*64 + w] is the only set bit of tap_sel[c*64 +: 64], where w is the wiper value of channel c.
- R3: Units are addressed by cmd_unit: 0 and 1 are the wipers of channels 0 and 1, and 2 and 3 are their control units. Op 2 writes cmd_data to the live register, with effect on the next cycle. Op 1 returns it on rd_data with rd_valid high for one cycle after the command edge.
- R4: In a control value, bit 5 is enable, bit 4 is hold and bit 3 is power-down. Bits 2..0 are stored and read as 0.
- R5: Op 3 reads slot cmd_slot of the unit. Op 4 writes cmd_data into that slot as a nonvolatile write.
- R6: Op 5 copies slot cmd_slot into the live register of the addressed unit. With cmd_all=1 it does so for all four units. Other units keep their values.
- R7: Op 6 copies the live register into slot cmd_slot, for one unit or, with cmd_all=1, for all units. Every nonvolatile write holds busy high for exactly WR_CYCLES cycles.
- R8: A command presented while busy is high is ignored: no register changes and no read response.
- R9: With wp_n low, ops 4 and 6 leave every slot unchanged and do not raise busy.
- R10: Op 7 moves a wiper up one tap if cmd_data[0]=1 and down one tap otherwise. It saturates at 63 and 0. On a control unit it has no effect.
- R11: cmp_out[c] is 0 when power-down is set or enable is clear. Otherwise it follows cmp_raw[c]. ana_off[c] equals the power-down bit.
- R12: While hold is set, cmp_out[c] keeps the cmp_raw[c] value sampled on the clock edge where hold became set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, recalls slot 0 |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code (1..7) |
| cmd_unit | input | 2 | Unit select |
| cmd_slot | input | 2 | Slot select |
| cmd_all | input | 1 | Apply copy to all units |
| cmd_data | input | 6 | Write data or step direction |
| wp_n | input | 1 | Low blocks nonvolatile writes |
| cmp_raw | input | 2 | Raw comparator results |
| rd_data | output | 6 | Read response data |
| rd_valid | output | 1 | Read response strobe |
| busy | output | 1 | Nonvolatile write in progress |
| tap_sel | output | 128 | One-hot tap enables, 64 per channel |
| ana_off | output | 2 | Analog power-down per channel |
| cmp_out | output | 2 | Gated comparator outputs |

## Verification
The bench builds the block with WR_CYCLES set to 20 in place of a realistic millisecond-scale count. This lets it measure the busy window to the exact cycle and issue commands inside it. The channel, tap and slot counts stay at their defaults, so the tap index arithmetic, the saturation at tap 63 and the control-bit layout are exercised exactly as deployed. Slots are first programmed through the host path, and a second reset then shows the recall from slot 0.

// File: rtl/potbank_ctrl.sv
module potbank_ctrl #(
  parameter int NCH       = 2,
  parameter int TAP_W     = 6,
  parameter int NSLOT     = 4,
  parameter int WR_CYCLES = 1000000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [3:0]                cmd_op,
  input  logic [$clog2(2*NCH)-1:0]  cmd_unit,
  input  logic [$clog2(NSLOT)-1:0]  cmd_slot,
  input  logic                      cmd_all,
  input  logic [TAP_W-1:0]          cmd_data,
  input  logic                      wp_n,
  input  logic [NCH-1:0]            cmp_raw,
  output logic [TAP_W-1:0]          rd_data,
  output logic                      rd_valid,
  output logic                      busy,
  output logic [NCH*(1<<TAP_W)-1:0] tap_sel,
  output logic [NCH-1:0]            ana_off,
  output logic [NCH-1:0]            cmp_out
);
  localparam int NU   = 2 * NCH;
  localparam int UW   = $clog2(NU);
  localparam int TAPS = 1 << TAP_W;
  localparam int CW   = $clog2(WR_CYCLES + 1);
  localparam int EN_B = TAP_W - 1;
  localparam int HD_B = TAP_W - 2;
  localparam int PD_B = TAP_W - 3;
  localparam logic [UW-1:0]    NCH_U = UW'(NCH);
  localparam logic [TAP_W-1:0] TOP   = {TAP_W{1'b1}};
  localparam logic [TAP_W-1:0] CMASK = {3'b111, {(TAP_W-3){1'b0}}};

  localparam logic [3:0] OP_RDV = 4'h1, OP_WRV = 4'h2, OP_RDS = 4'h3,
                         OP_WRS = 4'h4, OP_RCL = 4'h5, OP_SAV = 4'h6, OP_STP = 4'h7;

  logic [TAP_W-1:0] vol  [NU];
  logic [TAP_W-1:0] slot [NU][NSLOT];
  logic [CW-1:0]    cnt;
  logic [NCH-1:0]   hold_q;

  wire go    = cmd_valid && (cnt == '0);
  wire nv_op = (cmd_op == OP_WRS) || (cmd_op == OP_SAV);

  assign busy = (cnt != '0);

  function automatic logic [TAP_W-1:0] fix(input logic [UW-1:0] u, input logic [TAP_W-1:0] v);
    return (u >= NCH_U) ? (v & CMASK) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int u = 0; u < NU; u++) vol[u] <= fix(UW'(u), slot[u][0]);
    end else if (go) begin
      case (cmd_op)
        OP_WRV: vol[cmd_unit] <= fix(cmd_unit, cmd_data);
        OP_RCL:
          for (int u = 0; u < NU; u++)
            if (cmd_all || UW'(u) == cmd_unit) vol[u] <= fix(UW'(u), slot[u][cmd_slot]);
        OP_STP:
          if (cmd_unit < NCH_U) begin
            if (cmd_data[0]) begin
              if (vol[cmd_unit] != TOP) vol[cmd_unit] <= vol[cmd_unit] + 1'b1;
            end else if (vol[cmd_unit] != '0) begin
              vol[cmd_unit] <= vol[cmd_unit] - 1'b1;
            end
          end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && go && wp_n) begin
      if (cmd_op == OP_WRS) slot[cmd_unit][cmd_slot] <= fix(cmd_unit, cmd_data);
      if (cmd_op == OP_SAV)
        for (int u = 0; u < NU; u++)
          if (cmd_all || UW'(u) == cmd_unit) slot[u][cmd_slot] <= vol[u];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (go && cmd_op == OP_RDV) begin
        rd_data  <= vol[cmd_unit];
        rd_valid <= 1'b1;
      end
      if (go && cmd_op == OP_RDS) begin
        rd_data  <= slot[cmd_unit][cmd_slot];
        rd_valid <= 1'b1;
      end
      if (go && nv_op && wp_n) cnt <= CW'(WR_CYCLES);
      else if (cnt != '0)      cnt <= cnt - 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [TAP_W-1:0] ctl;
    assign ctl = vol[NCH + c];

    always_ff @(posedge clk) begin
      if (!rst_n) hold_q[c] <= 1'b0;
      else if (!ctl[HD_B]) hold_q[c] <= cmp_raw[c];
    end

    assign tap_sel[c*TAPS +: TAPS] = TAPS'(1) << vol[c];
    assign ana_off[c] = ctl[PD_B];
    assign cmp_out[c] = !ctl[PD_B] && ctl[EN_B] && (ctl[HD_B] ? hold_q[c] : cmp_raw[c]);

    // R11
    pd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ana_off[c] |-> !cmp_out[c]);
    // R12
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[HD_B] && $past(ctl[HD_B]) && $stable(ctl)) |-> $stable(cmp_out[c]));
  end

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> (!rd_valid && $stable(vol[0]) && $stable(vol[NCH])));
  // R9
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && nv_op && !wp_n) |=> !busy);
  // R7
  nv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && nv_op && wp_n) |=> busy);
  // R10
  step_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_op == OP_STP && cmd_unit == '0 && cmd_data[0] && vol[0] == TOP) |=> (vol[0] == TOP));
  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid || $past(go));
endmodule

// File: tb/sim_potbank_ctrl.sv
`timescale 1ns/1ps
module sim_potbank_ctrl;
  localparam int WRC = 20;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, cmd_all = 1'b0, wp_n = 1'b1;
  logic [3:0] cmd_op = '0;
  logic [1:0] cmd_unit = '0, cmd_slot = '0, cmp_raw = '0;
  logic [5:0] cmd_data = '0, rd_data;
  logic rd_valid, busy;
  logic [127:0] tap_sel;
  logic [1:0] ana_off, cmp_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  potbank_ctrl #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_unit(cmd_unit),
    .cmd_slot(cmd_slot), .cmd_all(cmd_all), .cmd_data(cmd_data), .wp_n(wp_n), .cmp_raw(cmp_raw),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .tap_sel(tap_sel),
    .ana_off(ana_off), .cmp_out(cmp_out));

  task automatic chk(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic issue(logic [3:0] op, logic [1:0] un, logic [1:0] sl, logic all, logic [5:0] d);
    @(negedge clk);
    cmd_op = op; cmd_unit = un; cmd_slot = sl; cmd_all = all; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(string req, logic [3:0] op, logic [1:0] un, logic [1:0] sl, logic [5:0] exp);
    issue(op, un, sl, 1'b0, 6'd0);
    chk({req, " rd_valid"}, rd_valid, 1'b1);
    chk({req, " rd_data"}, rd_data, exp);
  endtask

  task automatic wait_idle(string req, int exp_len);
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    if (exp_len >= 0) chk({req, " busy length"}, n, exp_len);
  endtask

  function automatic logic [127:0] taps(int a, int b);
    return (128'd1 << a) | (128'd1 << (64 + b));
  endfunction

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 1'b0);
    chk("R1 rd_valid after reset", rd_valid, 1'b0);
  endtask

  task automatic t_program;
    issue(4, 0, 0, 0, 6'd10);
    chk("R5 write slot starts busy", busy, 1'b1);
    wait_idle("R7 slot write", WRC);
    issue(4, 1, 0, 0, 6'd63); wait_idle("R5", -1);
    issue(4, 2, 0, 0, 6'h3F); wait_idle("R5", -1);
    issue(4, 3, 0, 0, 6'h28); wait_idle("R5", -1);
    rd("R5 slot read u0", 3, 0, 0, 6'd10);
    rd("R4 slot read masked u2", 3, 2, 0, 6'h38);
  endtask

  task automatic t_recall_reset;
    cmp_raw = 2'b11;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 R2 taps from slot0", tap_sel, taps(10, 63));
    rd("R1 ctl u2 recalled", 1, 2, 0, 6'h38);
    rd("R1 ctl u3 recalled", 1, 3, 0, 6'h28);
    chk("R11 power-down flags", ana_off, 2'b11);
    chk("R11 power-down forces low", cmp_out, 2'b00);
  endtask

  task automatic t_wrvol;
    issue(2, 0, 0, 0, 6'd33);
    chk("R2 R3 tap after write", tap_sel, taps(33, 63));
    rd("R3 live read u0", 1, 0, 0, 6'd33);
    issue(2, 2, 0, 0, 6'h27);
    rd("R4 low bits zero", 1, 2, 0, 6'h20);
    chk("R11 enabled passes 1", cmp_out[0], 1'b1);
    @(negedge clk); cmp_raw[0] = 1'b0; @(negedge clk);
    chk("R11 enabled passes 0", cmp_out[0], 1'b0);
    cmp_raw[0] = 1'b1;
    issue(2, 2, 0, 0, 6'h00);
    chk("R11 disabled output low", cmp_out[0], 1'b0);
  endtask

  task automatic t_latch;
    issue(2, 2, 0, 0, 6'h20);
    issue(2, 2, 0, 0, 6'h30);
    cmp_raw[0] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 hold keeps captured 1", cmp_out[0], 1'b1);
    issue(2, 2, 0, 0, 6'h20);
    chk("R12 released follows raw", cmp_out[0], 1'b0);
  endtask

  task automatic t_step;
    issue(2, 1, 0, 0, 6'd62);
    issue(7, 1, 0, 0, 6'd1);
    rd("R10 step up", 1, 1, 0, 6'd63);
    issue(7, 1, 0, 0, 6'd1);
    rd("R10 saturate at top", 1, 1, 0, 6'd63);
    issue(2, 0, 0, 0, 6'd1);
    issue(7, 0, 0, 0, 6'd0);
    issue(7, 0, 0, 0, 6'd0);
    rd("R10 saturate at bottom", 1, 0, 0, 6'd0);
    issue(7, 2, 0, 0, 6'd1);
    rd("R10 control unit unchanged", 1, 2, 0, 6'h20);
  endtask

  task automatic t_save_recall;
    issue(2, 0, 0, 0, 6'd17);
    issue(2, 1, 0, 0, 6'd5);
    issue(6, 0, 2, 1, 6'd0);
    wait_idle("R7 global save", WRC);
    rd("R7 saved u0", 3, 0, 2, 6'd17);
    rd("R7 saved u1", 3, 1, 2, 6'd5);
    rd("R7 saved u3", 3, 3, 2, 6'h28);
    issue(2, 0, 0, 0, 6'd0);
    issue(2, 1, 0, 0, 6'd9);
    issue(5, 0, 2, 0, 6'd0);
    chk("R6 single recall", tap_sel, taps(17, 9));
    issue(5, 0, 2, 1, 6'd0);
    chk("R6 global recall", tap_sel, taps(17, 5));
  endtask

  task automatic t_busy;
    issue(2, 0, 0, 0, 6'd40);
    issue(6, 0, 3, 0, 6'd0);
    issue(2, 0, 0, 0, 6'd1);
    chk("R8 write ignored while busy", tap_sel, taps(40, 5));
    issue(1, 0, 0, 0, 6'd0);
    chk("R8 read ignored while busy", rd_valid, 1'b0);
    wait_idle("R8", -1);
    rd("R7 single save", 3, 0, 3, 6'd40);
  endtask

  task automatic t_wp;
    wp_n = 1'b0;
    issue(4, 0, 3, 0, 6'd2);
    chk("R9 protected slot write no busy", busy, 1'b0);
    issue(2, 0, 0, 0, 6'd41);
    issue(6, 0, 3, 0, 6'd0);
    chk("R9 protected save no busy", busy, 1'b0);
    rd("R9 slot unchanged", 3, 0, 3, 6'd40);
    wp_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_program();
    t_recall_reset();
    t_wrvol();
    t_latch();
    t_step();
    t_save_recall();
    t_busy();
    t_wp();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule